// File: doc/BRIEF.md
# Cell Interface Slave Receiver

This block sits on the receive side of a slave device on a cell-based parallel interface. A master moves fixed-length cells across it on a 100 MHz interface clock. The master polls the slave through an 8-bit address bus. For each of its ports, the slave answers with a cell-available line that is high only while that port's buffer has room for a whole cell.

To select a port, the master drives its address during a cycle in which the active-low enable is high. Once a port is selected, every cycle with the enable low transfers one data word. The start-of-cell strobe marks the first word of each cell. The block frames the cell, counts its words and forwards each one to the cell buffer. The first and last words carry markers.

Each accepted word must carry odd parity, and the block checks it. Two faults each set a sticky framing error: a start-of-cell inside a partly received cell, and a word that arrives with no cell open. In the first case the block also tells the buffer to discard the partial cell. The data width is 8, 16 or 32 bits, set by a parameter.

Top module: `cellrx_slave`

## Requirements
- R1: After reset every output is 0: cell-available lines, word valid, first and last markers, discard pulse, and both error flags.
- R2: Cell-available line i is 1 in the cycle after one in which the poll address equals BASE_ADDR+i and room bit i is 1. In every other cycle it is 0.
- R3: A cycle with the enable high and a poll address in BASE_ADDR..BASE_ADDR+CLAV_W-1 selects port (address − BASE_ADDR). A cycle with the enable high and any other address deselects. While the block is deselected, cycles with the enable low produce no output word.
- R4: A word is accepted only in a cycle with the enable low while a port is selected. In the following cycle the word appears on the output with valid high, together with the selected port number.
- R5: An accepted word with start-of-cell high opens a cell and is output with the first marker. The CELL_WORDS-th word of a cell is output with the last marker and closes the cell.
- R6: An accepted start-of-cell word while a cell is open raises the discard pulse for one cycle, together with the new cell's first word. It also sets the framing error.
- R7: An accepted word without start-of-cell while no cell is open is not forwarded, and it sets the framing error.
- R8: Odd parity is checked on every accepted word. A word whose data bits and parity bit hold an even number of ones sets the parity error. The word is still forwarded.
- R9: Both error flags stay at 1 once set, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low reset |
| rx_word | input | DATA_W | Data word from the master |
| word_enb_n | input | 1 | Active-low transfer enable |
| cell_start | input | 1 | Start-of-cell strobe |
| word_par | input | 1 | Odd parity over rx_word |
| poll_addr | input | 8 | Poll and select address |
| port_room | input | CLAV_W | Per-port buffer has room for a whole cell |
| cell_avail | output | CLAV_W | Per-port cell-available lines |
| out_valid | output | 1 | Forwarded word valid |
| out_data | output | DATA_W | Forwarded word |
| out_first | output | 1 | First word of a cell |
| out_last | output | 1 | Last word of a cell |
| out_port | output | PORT_W | Port the word belongs to |
| out_drop | output | 1 | Discard the partial cell received so far |
| parity_err | output | 1 | Sticky parity error |
| frame_err | output | 1 | Sticky framing error |

## Verification
A wrong word count or lost cell-open state shows up at the end of the cell it corrupts. Within at most CELL_WORDS accepted words, the last marker moves, or the block raises a discard or framing error that should not occur. A wrong selection state shows up on the first enabled cycle after the address phase, as a word that is missing, extra or tagged with the wrong port. The behavioural model is compared against every output on every clock, so any difference is reported in the cycle it first reaches the ports.

// File: rtl/cellrx_pkg.sv
package cellrx_pkg;

    // odd parity: data bits plus parity bit hold an odd count of ones
    function automatic logic odd_ok(input logic lane_xor, input logic par);
        return lane_xor ^ par;
    endfunction

endpackage

// File: rtl/cellrx_parity.sv
module cellrx_parity #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] word,
    input  logic              par,
    output logic              ok
);
    localparam int LANES = DATA_W / 8;

    logic [LANES-1:0] lane_x;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_x[g] = ^word[g*8 +: 8];
    end

    assign ok = cellrx_pkg::odd_ok(^lane_x, par);
endmodule

// File: rtl/cellrx_addr_dec.sv
module cellrx_addr_dec #(
    parameter int         CLAV_W    = 1,
    parameter logic [7:0] BASE_ADDR = 8'h04,
    localparam int        PORT_W    = (CLAV_W > 1) ? $clog2(CLAV_W) : 1
) (
    input  logic [7:0]        addr,
    input  logic [CLAV_W-1:0] room,
    output logic [CLAV_W-1:0] avail,
    output logic              hit,
    output logic [PORT_W-1:0] hit_idx
);
    logic [CLAV_W-1:0] match;

    for (genvar g = 0; g < CLAV_W; g++) begin : g_line
        localparam logic [7:0] LINE_ADDR = 8'(BASE_ADDR + g);
        assign match[g] = (addr == LINE_ADDR);
        assign avail[g] = match[g] & room[g];
    end

    always_comb begin
        hit     = |match;
        hit_idx = '0;
        for (int i = 0; i < CLAV_W; i++) begin
            if (match[i]) hit_idx = PORT_W'(i);
        end
    end
endmodule

// File: rtl/cellrx_slave.sv
module cellrx_slave #(
    parameter int         DATA_W     = 8,
    parameter int         CELL_WORDS = 53,
    parameter int         CLAV_W     = 1,
    parameter logic [7:0] BASE_ADDR  = 8'h04,
    localparam int        PORT_W     = (CLAV_W > 1) ? $clog2(CLAV_W) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] rx_word,
    input  logic              word_enb_n,
    input  logic              cell_start,
    input  logic              word_par,
    input  logic [7:0]        poll_addr,
    input  logic [CLAV_W-1:0] port_room,
    output logic [CLAV_W-1:0] cell_avail,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_first,
    output logic              out_last,
    output logic [PORT_W-1:0] out_port,
    output logic              out_drop,
    output logic              parity_err,
    output logic              frame_err
);
    localparam int CNT_W = $clog2(CELL_WORDS + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CELL_WORDS - 1);

    typedef struct packed {
        logic              sel;
        logic [PORT_W-1:0] port;
        logic [CNT_W-1:0]  cnt;
        logic [CLAV_W-1:0] clav;
        logic              vld;
        logic [DATA_W-1:0] data;
        logic              first;
        logic              last;
        logic [PORT_W-1:0] oport;
        logic              drop;
        logic              perr;
        logic              ferr;
    } state_t;

    state_t st_d, st_q;

    logic [CLAV_W-1:0] avail_d;
    logic              hit;
    logic [PORT_W-1:0] hit_idx;
    logic              par_ok;

    cellrx_addr_dec #(.CLAV_W(CLAV_W), .BASE_ADDR(BASE_ADDR)) i_dec (
        .addr(poll_addr), .room(port_room), .avail(avail_d),
        .hit(hit), .hit_idx(hit_idx)
    );

    cellrx_parity #(.DATA_W(DATA_W)) i_par (
        .word(rx_word), .par(word_par), .ok(par_ok)
    );

    always_comb begin
        st_d       = st_q;
        st_d.clav  = avail_d;
        st_d.vld   = 1'b0;
        st_d.first = 1'b0;
        st_d.last  = 1'b0;
        st_d.drop  = 1'b0;
        if (word_enb_n) begin
            st_d.sel = hit;
            if (hit) st_d.port = hit_idx;
        end else if (st_q.sel) begin
            if (!par_ok) st_d.perr = 1'b1;
            if (cell_start) begin
                if (st_q.cnt != '0) begin
                    st_d.drop = 1'b1;
                    st_d.ferr = 1'b1;
                end
                st_d.vld   = 1'b1;
                st_d.first = 1'b1;
                st_d.data  = rx_word;
                st_d.oport = st_q.port;
                if (CELL_WORDS == 1) begin
                    st_d.last = 1'b1;
                    st_d.cnt  = '0;
                end else begin
                    st_d.cnt = CNT_W'(1);
                end
            end else if (st_q.cnt == '0) begin
                st_d.ferr = 1'b1;
            end else begin
                st_d.vld   = 1'b1;
                st_d.data  = rx_word;
                st_d.oport = st_q.port;
                if (st_q.cnt == LAST_IDX) begin
                    st_d.last = 1'b1;
                    st_d.cnt  = '0;
                end else begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cell_avail = st_q.clav;
    assign out_valid  = st_q.vld;
    assign out_data   = st_q.data;
    assign out_first  = st_q.first;
    assign out_last   = st_q.last;
    assign out_port   = st_q.oport;
    assign out_drop   = st_q.drop;
    assign parity_err = st_q.perr;
    assign frame_err  = st_q.ferr;

    // R2
    avail_needs_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|cell_avail) |-> $past(|port_room));
    // R4
    valid_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(!word_enb_n));
    // R5
    last_is_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);
    // R6
    drop_with_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_drop |-> (frame_err && out_first && $past(cell_start)));
    // R9
    perr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        parity_err |=> parity_err);
    // R9
    ferr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> frame_err);
endmodule

// File: tb/test_cellrx_slave.sv
module test_cellrx_slave;
    localparam int         DW    = 16;
    localparam int         CW    = 5;
    localparam int         NP    = 2;
    localparam logic [7:0] BASE  = 8'h10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] d_word = '0;
    logic          d_enb_n = 1'b1;
    logic          d_soc = 1'b0;
    logic          d_par = 1'b1;
    logic [7:0]    d_addr = 8'hFF;
    logic [NP-1:0] d_room = '0;

    logic [NP-1:0] cell_avail;
    logic          out_valid, out_first, out_last, out_drop, parity_err, frame_err;
    logic [DW-1:0] out_data;
    logic [0:0]    out_port;

    cellrx_slave #(.DATA_W(DW), .CELL_WORDS(CW), .CLAV_W(NP), .BASE_ADDR(BASE)) i_cellrx_slave (
        .clk(clk), .rst_n(rst_n), .rx_word(d_word), .word_enb_n(d_enb_n),
        .cell_start(d_soc), .word_par(d_par), .poll_addr(d_addr), .port_room(d_room),
        .cell_avail(cell_avail), .out_valid(out_valid), .out_data(out_data),
        .out_first(out_first), .out_last(out_last), .out_port(out_port),
        .out_drop(out_drop), .parity_err(parity_err), .frame_err(frame_err)
    );

    always #10 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // behavioural reference
    bit            m_sel;
    int            m_port, m_cnt;
    logic [NP-1:0] e_clav;
    bit            e_vld, e_first, e_last, e_drop, e_perr, e_ferr;
    logic [DW-1:0] e_data;
    int            e_port;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sel = 0; m_port = 0; m_cnt = 0; e_clav = '0; e_vld = 0; e_first = 0;
            e_last = 0; e_drop = 0; e_perr = 0; e_ferr = 0; e_data = '0; e_port = 0;
        end else begin
            e_clav = '0;
            for (int i = 0; i < NP; i++)
                if (int'(d_addr) == int'(BASE) + i && d_room[i]) e_clav[i] = 1'b1;
            e_vld = 0; e_first = 0; e_last = 0; e_drop = 0;
            if (d_enb_n) begin
                if (int'(d_addr) >= int'(BASE) && int'(d_addr) < int'(BASE) + NP) begin
                    m_sel = 1; m_port = int'(d_addr) - int'(BASE);
                end else m_sel = 0;
            end else if (m_sel) begin
                if (((^d_word) ^ d_par) == 1'b0) e_perr = 1;
                if (d_soc) begin
                    if (m_cnt > 0) begin e_drop = 1; e_ferr = 1; end
                    e_vld = 1; e_first = 1; e_data = d_word; e_port = m_port; m_cnt = 1;
                end else if (m_cnt == 0) begin
                    e_ferr = 1;
                end else begin
                    e_vld = 1; e_data = d_word; e_port = m_port; m_cnt++;
                    if (m_cnt == CW) begin e_last = 1; m_cnt = 0; end
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk(cell_avail == e_clav, "R2 cell_avail", cell_avail, e_clav);
        chk(out_valid == e_vld, "R4 out_valid", out_valid, e_vld);
        if (e_vld) begin
            chk(out_data == e_data, "R4 out_data", out_data, e_data);
            chk(int'(out_port) == e_port, "R4 out_port", out_port, e_port);
        end
        chk(out_first == e_first, "R5 out_first", out_first, e_first);
        chk(out_last == e_last, "R5 out_last", out_last, e_last);
        chk(out_drop == e_drop, "R6 out_drop", out_drop, e_drop);
        chk(parity_err == e_perr, "R8 parity_err", parity_err, e_perr);
        chk(frame_err == e_ferr, "R7 frame_err", frame_err, e_ferr);
    endtask

    // one cycle: check outputs, then drive new inputs away from the edge
    task automatic step(input bit enb_n, input bit soc, input logic [DW-1:0] w,
                        input logic [7:0] a, input logic [NP-1:0] rm, input bit bad);
        @(negedge clk);
        if (rst_n) compare();
        d_enb_n = enb_n; d_soc = soc; d_word = w; d_addr = a; d_room = rm;
        d_par = ~(^w) ^ bad;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        d_enb_n = 1'b1; d_soc = 1'b0; d_addr = 8'hFF; d_room = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk({cell_avail, out_valid, out_first, out_last, out_drop, parity_err, frame_err} == '0,
            "R1 reset outputs", {cell_avail, out_valid, parity_err, frame_err}, 0);
        rst_n = 1'b1;

        // R2 polling
        step(1, 0, 0, 8'h10, 2'b01, 0);
        step(1, 0, 0, 8'h11, 2'b01, 0);
        step(1, 0, 0, 8'h11, 2'b11, 0);
        step(1, 0, 0, 8'h20, 2'b11, 0);
        step(1, 0, 0, 8'h0F, 2'b11, 0);

        // R3/R4/R5: select port 0, full cell
        step(1, 0, 0, 8'h10, 2'b11, 0);
        for (int i = 0; i < CW; i++) step(0, i == 0, 16'hA000 + 16'(i), 8'h55, 2'b11, 0);
        // R3: deselect and try to push words
        step(1, 0, 0, 8'h33, 2'b00, 0);
        for (int i = 0; i < 4; i++) step(0, i == 0, 16'hBEEF, 8'h44, 2'b00, 0);
        @(negedge clk);
        compare();
        chk(out_valid == 1'b0, "R3 deselected words ignored", out_valid, 0);
        d_enb_n = 1'b1;

        // R8: port 1, cell with a parity fault
        step(1, 0, 0, 8'h11, 2'b10, 0);
        for (int i = 0; i < CW; i++) step(0, i == 0, 16'h0F0F ^ 16'(i * 3), 8'h00, 2'b10, i == 2);
        step(1, 0, 0, 8'h11, 2'b10, 0);

        // R6: start-of-cell inside a cell
        step(0, 1, 16'h1111, 8'h11, 0, 0);
        step(0, 0, 16'h2222, 8'h11, 0, 0);
        step(0, 1, 16'h3333, 8'h11, 0, 0);
        for (int i = 1; i < CW; i++) step(0, 0, 16'h3330 + 16'(i), 8'h11, 0, 0);
        step(1, 0, 0, 8'h11, 0, 0);
        step(1, 0, 0, 8'h11, 0, 0);
        chk(parity_err && frame_err, "R9 errors held", {parity_err, frame_err}, 2'b11);

        // R1/R9: reset clears errors
        do_reset();
        @(negedge clk);
        chk(!parity_err && !frame_err, "R1 R9 cleared by reset", {parity_err, frame_err}, 0);

        // R7: orphan word while no cell open
        step(1, 0, 0, 8'h10, 0, 0);
        step(0, 0, 16'h7777, 8'h10, 0, 0);
        step(1, 0, 0, 8'h10, 0, 0);
        chk(frame_err && !out_valid, "R7 orphan word", {frame_err, out_valid}, 2'b10);

        // mixed traffic
        for (int c = 0; c < 600; c++) begin
            int r = int'($urandom % 100);
            if (r < 15)
                step(1, 0, 0, 8'(8'h0F + $urandom % 4), 2'($urandom), 0);
            else
                step(0, ($urandom % 7) == 0, 16'($urandom), 8'($urandom), 2'($urandom),
                     ($urandom % 40) == 0);
        end
        step(1, 0, 0, 8'hFF, 0, 0);
        step(1, 0, 0, 8'hFF, 0, 0);
        finish_run();
    end
endmodule